// File: doc/BRIEF.md
# SPI Register Bank Target

This block is a serial peripheral target. An external master uses it to read and write a small bank of byte-wide configuration and timekeeping registers. Internal logic sees every register at once through a flat parallel view. It also gets two decoded control bits: a power-on-reset override flag and a test-mode flag.

A transaction is framed by an active-high enable. The first byte the master shifts in is a command. The command selects read or write, carries a fixed subaddress that must match, and gives a starting register address. Each byte after the command is one data byte. In a write it is stored at the current address. In a read the current register is returned on the serial output, most significant bit first. After each data byte the address moves to the next register. After the last implemented register it goes back to 0. The serial pins are sampled by the block's own system clock. The serial clock must idle low, and each of its phases must last several system clock cycles.

Top module: `spi_regbank`

## Requirements
- R1: While `spi_en` is low, serial clock and data activity is ignored: no register changes, `spi_miso` is 0, and the next transaction starts cleanly with a command byte.
- R2: The first byte of a transaction is the command. Bit 7 is the direction (1 = read, 0 = write), bits 6:4 are a subaddress that must equal parameter `SUBADDR` (default 3'b101), and bits 3:0 are the starting register address.
- R3: In a write transaction, each complete data byte is stored in the register at the current address. The bytes are sent MSB first.
- R4: Serial data is sampled on rising serial clock edges. A byte takes effect on the falling edge that follows its eighth rising edge.
- R5: After each data byte the address advances by one. After register `NREG-1` it returns to 0, even when `NREG` is not a power of two.
- R6: In a read transaction, the MSB of the addressed register is driven on the falling edge that ends the command byte. Each later falling edge drives the next bit, so a burst returns consecutive registers.
- R7: Register 0 bit 3 is the power-on-reset override flag. It resets to 1, writing 0 clears it, and its value appears on `por_override`.
- R8: Register 0 bit 5 is the test-mode flag. It resets to 0, its value appears on `test_mode`, and writes to every register work with it at 0.
- R9: If the subaddress does not match, or the start address is not below `NREG`, the rest of the transaction changes no register and `spi_miso` stays 0.
- R10: If fewer than eight bits of a data byte are received when `spi_en` falls, the partial byte is discarded and its register is unchanged.
- R11: After reset, every register other than register 0 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, idles low |
| spi_en | input | 1 | Active-high transaction enable |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when idle |
| reg_view | output | NREG*8 | All registers; register i in bits [8i+7:8i] |
| por_override | output | 1 | Power-on-reset override flag (register 0 bit 3) |
| test_mode | output | 1 | Test-mode flag (register 0 bit 5) |

## Verification
On every cycle, the assertions check four things. The output is quiet whenever the synchronised enable is low. The bit counter never goes past a full byte. The address pointer stays inside the bank. Registers change only at a completed byte boundary and never during an ignored transaction. The bench scenarios are the only way to show data values and order. These cover bursts that wrap at a bank size that is not a power of two, a burst read starting in the middle of the bank, the bit order of read data, a partial-byte abort, a subaddress mismatch and the reset values of the two control flags.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int NREG = 16,
  parameter logic [2:0] SUBADDR = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_en,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [NREG*8-1:0] reg_view,
  output logic              por_override,
  output logic              test_mode
);
  localparam int AW = 4;
  localparam int OVR_BIT = 3;
  localparam int TST_BIT = 5;
  localparam logic [7:0] REG0_RST = 8'h01 << OVR_BIT;
  localparam logic [1:0] S_CMD = 2'd0, S_WR = 2'd1, S_RD = 2'd2, S_IGN = 2'd3;

  logic [2:0]    sck_q;
  logic [1:0]    en_q, dat_q;
  logic          ce_a, rise, fall;
  logic [3:0]    bcnt;
  logic [1:0]    st;
  logic [7:0]    sh, tx;
  logic [AW-1:0] addr, nxt;
  logic [7:0]    regs [0:NREG-1];

  assign ce_a = en_q[1];
  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];
  assign nxt  = (addr == AW'(NREG-1)) ? '0 : addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; en_q <= '0; dat_q <= '0;
      bcnt <= '0; st <= S_CMD; sh <= '0; tx <= '0;
      addr <= '0; spi_miso <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= (i == 0) ? REG0_RST : 8'h00;
    end else begin
      sck_q <= {sck_q[1:0], spi_sck};
      en_q  <= {en_q[0], spi_en};
      dat_q <= {dat_q[0], spi_mosi};
      if (!ce_a) begin
        bcnt <= '0;
        st <= S_CMD;
        spi_miso <= 1'b0;
      end else if (rise) begin
        sh <= {sh[6:0], dat_q[1]};
        bcnt <= bcnt + 1'b1;
      end else if (fall) begin
        if (bcnt == 4'd8) begin
          bcnt <= '0;
          case (st)
            S_CMD: begin
              if (sh[6:4] == SUBADDR && sh[3:0] < NREG) begin
                addr <= sh[3:0];
                if (sh[7]) begin
                  st <= S_RD;
                  spi_miso <= regs[sh[3:0]][7];
                  tx <= {regs[sh[3:0]][6:0], 1'b0};
                end else begin
                  st <= S_WR;
                end
              end else begin
                st <= S_IGN;
              end
            end
            S_WR: begin
              regs[addr] <= sh;
              addr <= nxt;
            end
            S_RD: begin
              addr <= nxt;
              spi_miso <= regs[nxt][7];
              tx <= {regs[nxt][6:0], 1'b0};
            end
            default: ;
          endcase
        end else if (st == S_RD) begin
          spi_miso <= tx[7];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign reg_view[g*8 +: 8] = regs[g];
  end

  assign por_override = regs[0][OVR_BIT];
  assign test_mode    = regs[0][TST_BIT];
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_a,
  input logic              miso,
  input logic [3:0]        bcnt,
  input logic [1:0]        st,
  input logic [3:0]        addr,
  input logic [NREG*8-1:0] reg_view
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_a |=> !miso);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_a |=> $stable(reg_view));

  assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd8);

  assert_commit_at_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != 4'd8) |=> $stable(reg_view));

  assert_addr_in_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr < NREG);

  assert_ignored_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |=> $stable(reg_view) && !miso);
endmodule

bind spi_regbank spi_regbank_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_a(ce_a), .miso(spi_miso),
  .bcnt(bcnt), .st(st), .addr(addr), .reg_view(reg_view)
);

// File: tb/spi_regbank_tb.sv
module spi_regbank_tb;
  localparam int NREG = 12;
  localparam logic [2:0] SUB = 3'b101;
  localparam int HALF = 8;
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {4'd1, 8'h3C}, {4'd4, 8'hA5}, {4'd7, 8'h81},
    {4'd11, 8'h7E}, {4'd6, 8'hFF}, {4'd0, 8'h00}
  };

  logic clk = 0, rst_n = 0, sck = 0, en = 0, mosi = 0;
  logic miso, por_override, test_mode;
  logic [NREG*8-1:0] reg_view;
  logic [7:0] model [NREG];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_regbank #(.NREG(NREG), .SUBADDR(SUB)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_en(en), .spi_mosi(mosi),
    .spi_miso(miso), .reg_view(reg_view), .por_override(por_override),
    .test_mode(test_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, reg_view[i*8 +: 8], model[i]);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic open_t;
    @(negedge clk); en = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_t;
    repeat (HALF) @(negedge clk);
    en = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr_burst(input logic [3:0] a, input logic [7:0] d [], input logic [2:0] sub);
    logic [7:0] r;
    open_t;
    bits({1'b0, sub, a}, 8, r);
    foreach (d[k]) bits(d[k], 8, r);
    close_t;
  endtask

  task automatic rd_burst(input logic [3:0] a, input int n, output logic [7:0] q [$]);
    logic [7:0] r;
    q = {};
    open_t;
    bits({1'b1, SUB, a}, 8, r);
    for (int k = 0; k < n; k++) begin
      bits(8'h00, 8, r);
      q.push_back(r);
    end
    close_t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q [$];
    logic [7:0] r;
    int a;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h08 : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check_bank("R11 R7 reset bank");
    check("R7 override reset", {7'd0, por_override}, 8'd1);
    check("R8 test flag reset", {7'd0, test_mode}, 8'd0);
    check("R1 idle miso", {7'd0, miso}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      wr_burst(VEC[v][11:8], '{VEC[v][7:0]}, SUB);
      model[VEC[v][11:8]] = VEC[v][7:0];
      check("R3 R4 vector write", reg_view[VEC[v][11:8]*8 +: 8], VEC[v][7:0]);
      rd_burst(VEC[v][11:8], 1, q);
      check("R6 vector readback", q[0], VEC[v][7:0]);
    end
    check("R7 override cleared", {7'd0, por_override}, 8'd0);
    check("R8 test flag after writes", {7'd0, test_mode}, 8'd0);
    check_bank("R3 bank after vectors");

    wr_burst(4'd10, '{8'h11, 8'h22, 8'h33, 8'h44}, SUB);
    model[10] = 8'h11; model[11] = 8'h22; model[0] = 8'h33; model[1] = 8'h44;
    check_bank("R5 write wrap");

    rd_burst(4'd5, 9, q);
    for (int k = 0; k < 9; k++) begin
      a = (5 + k) % NREG;
      check("R6 R5 burst read", q[k], model[a]);
    end

    open_t;
    bits({1'b0, SUB, 4'd2}, 8, r);
    bits(8'hAA, 8, r);
    bits(8'h55, 5, r);
    close_t;
    model[2] = 8'hAA;
    check("R10 full byte kept", reg_view[2*8 +: 8], 8'hAA);
    check("R10 partial byte dropped", reg_view[3*8 +: 8], model[3]);

    wr_burst(4'd3, '{8'h99}, 3'b010);
    check_bank("R9 subaddress mismatch");
    open_t;
    bits({1'b1, 3'b011, 4'd2}, 8, r);
    bits(8'h00, 8, r);
    close_t;
    check("R9 mismatch read quiet", r, 8'h00);
    wr_burst(4'd13, '{8'h5A}, SUB);
    check_bank("R9 start beyond bank");

    for (int k = 0; k < 11; k++) begin
      mosi = k[0];
      repeat (HALF) @(negedge clk); sck = 1;
      repeat (HALF) @(negedge clk); sck = 0;
      if (miso !== 1'b0) check("R1 miso during idle clocks", {7'd0, miso}, 8'd0);
    end
    check_bank("R1 idle clocks ignored");
    wr_burst(4'd8, '{8'hC3}, SUB);
    model[8] = 8'hC3;
    check("R1 R2 framing after idle clocks", reg_view[8*8 +: 8], 8'hC3);

    wr_burst(4'd0, '{8'h08}, SUB);
    model[0] = 8'h08;
    check("R7 override set by write", {7'd0, por_override}, 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule